// File: doc/BRIEF.md
# Scan Signature Compaction Register

A 16-bit register placed beside the scan path of a test-access bridge. It plays one of three parts, chosen by a two-bit mode input. As a select-mode shift register it sits in the chain: a seed can be loaded from TDI, or a stored signature can be unloaded through its serial output. As an on-mode compactor it stays out of the chain. It watches the serial data that the local ports send toward TDO and folds each bit into a signature. In off mode it keeps whatever it holds.

The register moves only on rising TCK edges while the TAP controller is in Shift-DR. In every other TAP state it keeps its value. Instruction decode and chain routing are outside this block. The block only receives the decoded mode and the TAP state.

Top module: `sig_compact_reg`

## Requirements
- R1: A synchronous active-high reset clears all 16 register bits to zero, so `sig_so` reads 0 after reset.
- R2: The register changes only on a rising clock edge where `tap_state` equals the Shift-DR code 4'h4. With any other state code it holds in every mode.
- R3: Mode codes are 2'b01 select, 2'b10 on and 2'b00 off. Code 2'b11 behaves as off.
- R4: In select mode each Shift-DR edge shifts the register one place toward bit 0, with `tdi` entering at bit 15. A seed presented LSB first is therefore held intact after 16 edges.
- R5: In select mode `chain_di` has no effect on the register.
- R6: In on mode each Shift-DR edge performs one signature step. Let fb = bit15 XOR `chain_di`. The next value is the register shifted one place toward bit 15 with 0 entering bit 0, then XORed with 16'h1021 when fb is 1 (polynomial x^16+x^12+x^5+1).
- R7: In on mode `tdi` has no effect on the register.
- R8: In off mode (2'b00 or 2'b11) the register holds through Shift-DR edges.
- R9: `sig_so` always equals register bit 0. A signature formed in on mode is therefore read out LSB first by 16 select-mode shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock (TCK); the register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tap_state | input | 4 | Current TAP controller state code; 4'h4 is Shift-DR |
| mode | input | 2 | Role: 00 off, 01 select, 10 on, 11 off |
| tdi | input | 1 | Serial data entering the register in select mode |
| chain_di | input | 1 | Chain data flowing from local ports to TDO, compacted in on mode |
| sig_so | output | 1 | Serial output, register bit 0 |

## Verification
The register state is visible at `sig_so` one bit at a time. A wrong feedback tap, a wrong shift direction or a missed hold therefore stays hidden until a select-mode unload. It then appears as a mismatch in the 16-bit word shifted out, at the exact bit position of the fault. A fault in the mode or state gating shows up on the first unload after the stray edge. A swapped serial input (tdi against chain_di) corrupts bit 15 of a loaded seed, which leaves the port 15 edges later. Each scenario therefore ends in a full unload and compares the whole word with an independently computed model.

// File: rtl/sig_pkg.sv
package sig_pkg;
  typedef enum logic [1:0] {
    SM_OFF    = 2'b00,
    SM_SELECT = 2'b01,
    SM_ON     = 2'b10,
    SM_FREEZE = 2'b11
  } sig_mode_e;

  localparam int unsigned SIG_W_DEF      = 16;
  localparam int unsigned ST_W_DEF       = 4;
  localparam logic [15:0] POLY_DEF       = 16'h1021;
  localparam logic [3:0]  SHIFT_DR_DEF   = 4'h4;
endpackage

// File: rtl/sig_ctrl.sv
module sig_ctrl #(
  parameter int unsigned       ST_W          = 4,
  parameter logic [ST_W-1:0]   SHIFT_DR_CODE = 4'h4
) (
  input  logic [ST_W-1:0] tap_state,
  input  logic [1:0]      mode,
  output logic            shift_en,
  output logic            comp_en
);
  import sig_pkg::*;

  logic      in_shift;
  sig_mode_e mode_e;

  assign in_shift = (tap_state == SHIFT_DR_CODE);
  assign mode_e   = sig_mode_e'(mode);

  always_comb begin
    shift_en = 1'b0;
    comp_en  = 1'b0;
    if (in_shift) begin
      unique case (mode_e)
        SM_SELECT: shift_en = 1'b1;
        SM_ON:     comp_en  = 1'b1;
        default: begin
          shift_en = 1'b0;
          comp_en  = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sig_core.sv
module sig_core #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         comp_en,
  input  logic         tdi,
  input  logic         chain_di,
  output logic [W-1:0] q
);
  // plain serial shift toward bit 0, new bit at the top
  function automatic logic [W-1:0] plain_shift(input logic [W-1:0] cur, input logic din);
    return {din, cur[W-1:1]};
  endfunction

  // one serial-input signature step
  function automatic logic [W-1:0] sig_step(input logic [W-1:0] cur, input logic din);
    logic          fb;
    logic [W-1:0]  nxt;
    fb  = cur[W-1] ^ din;
    nxt = {cur[W-2:0], 1'b0};
    for (int b = 0; b < W; b++) begin
      if (POLY[b]) nxt[b] = nxt[b] ^ fb;
    end
    return nxt;
  endfunction

  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (shift_en)     q_next = plain_shift(q, tdi);
    else if (comp_en) q_next = sig_step(q, chain_di);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end
endmodule

// File: rtl/sig_compact_reg.sv
module sig_compact_reg #(
  parameter int unsigned        W             = sig_pkg::SIG_W_DEF,
  parameter int unsigned        ST_W          = sig_pkg::ST_W_DEF,
  parameter logic [W-1:0]       POLY          = sig_pkg::POLY_DEF,
  parameter logic [ST_W-1:0]    SHIFT_DR_CODE = sig_pkg::SHIFT_DR_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] tap_state,
  input  logic [1:0]      mode,
  input  logic            tdi,
  input  logic            chain_di,
  output logic            sig_so
);
  logic         shift_en;
  logic         comp_en;
  logic [W-1:0] sig_q;

  sig_ctrl #(.ST_W(ST_W), .SHIFT_DR_CODE(SHIFT_DR_CODE)) u_ctrl (
    .tap_state (tap_state),
    .mode      (mode),
    .shift_en  (shift_en),
    .comp_en   (comp_en)
  );

  sig_core #(.W(W), .POLY(POLY)) u_core (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .comp_en  (comp_en),
    .tdi      (tdi),
    .chain_di (chain_di),
    .q        (sig_q)
  );

  assign sig_so = sig_q[0];
endmodule

// File: rtl/sig_compact_chk.sv
module sig_compact_chk #(
  parameter int unsigned      W             = 16,
  parameter int unsigned      ST_W          = 4,
  parameter logic [W-1:0]     POLY          = 16'h1021,
  parameter logic [ST_W-1:0]  SHIFT_DR_CODE = 4'h4
) (
  input logic            clk,
  input logic            rst,
  input logic [ST_W-1:0] tap_state,
  input logic [1:0]      mode,
  input logic            tdi,
  input logic            chain_di,
  input logic            shift_en,
  input logic            comp_en,
  input logic [W-1:0]    sig_q,
  input logic            sig_so
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> sig_q == '0); // R1

  AST_HOLD_OUTSIDE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (tap_state != SHIFT_DR_CODE) |=> $stable(sig_q)); // R2

  AST_ONE_ROLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({shift_en, comp_en})); // R3

  AST_SELECT_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (tap_state == SHIFT_DR_CODE && mode == 2'b01)
      |=> sig_q == {$past(tdi), $past(sig_q[W-1:1])}); // R4

  AST_COMP_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tap_state == SHIFT_DR_CODE && mode == 2'b10 && sig_q == '0 && chain_di)
      |=> sig_q == POLY); // R6

  AST_COMP_SHIFTS_UP: assert property (@(posedge clk) disable iff (rst)
    (tap_state == SHIFT_DR_CODE && mode == 2'b10)
      |=> sig_q[W-1:1] == ($past(sig_q[W-2:0]) ^ (POLY[W-1:1] & {(W-1){$past(sig_q[W-1] ^ chain_di)}}))); // R6

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (tap_state == SHIFT_DR_CODE && (mode == 2'b00 || mode == 2'b11)) |=> $stable(sig_q)); // R8

  always_comb begin
    AST_SO_IS_LSB: assert (sig_so == sig_q[0]); // R9
  end
endmodule

bind sig_compact_reg sig_compact_chk #(
  .W(W), .ST_W(ST_W), .POLY(POLY), .SHIFT_DR_CODE(SHIFT_DR_CODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tap_state (tap_state),
  .mode      (mode),
  .tdi       (tdi),
  .chain_di  (chain_di),
  .shift_en  (shift_en),
  .comp_en   (comp_en),
  .sig_q     (sig_q),
  .sig_so    (sig_so)
);

// File: tb/sig_compact_reg_test.sv
module sig_compact_reg_test;
  localparam time PERIOD = 20ns;
  localparam logic [3:0] ST_SHIFT = 4'h4;
  localparam logic [3:0] ST_PAUSE = 4'h3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tap_state = 4'h0;
  logic [1:0] mode = 2'b00;
  logic       tdi = 1'b0;
  logic       chain_di = 1'b0;
  logic       sig_so;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [15:0] model = 16'h0;

  sig_compact_reg uut (
    .clk(clk), .rst(rst), .tap_state(tap_state), .mode(mode),
    .tdi(tdi), .chain_di(chain_di), .sig_so(sig_so)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2ns;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model of one signature step, written as bit taps 12, 5 and 0
  function automatic logic [15:0] model_step(input logic [15:0] cur, input logic d);
    logic [15:0] n;
    logic t;
    t = cur[15] ^ d;
    n = cur << 1;
    n[12] = n[12] ^ t;
    n[5]  = n[5] ^ t;
    n[0]  = n[0] ^ t;
    return n;
  endfunction

  task automatic load_seed(input logic [15:0] seed, input logic noise);
    tap_state = ST_SHIFT; mode = 2'b01;
    for (int i = 0; i < 16; i++) begin
      tdi = seed[i]; chain_di = noise ^ i[0];
      tick();
    end
    model = seed;
  endtask

  task automatic unload(input string req, input logic [15:0] exp);
    logic [15:0] got;
    tap_state = ST_SHIFT; mode = 2'b01; tdi = 1'b0; chain_di = 1'b0;
    for (int i = 0; i < 16; i++) begin
      got[i] = sig_so;
      tick();
    end
    chk(req, got, exp);
    model = 16'h0;
  endtask

  task automatic compact(input logic [31:0] data, input int nbits, input logic tdi_val);
    tap_state = ST_SHIFT; mode = 2'b10;
    for (int i = 0; i < nbits; i++) begin
      chain_di = data[i]; tdi = tdi_val ^ i[1];
      tick();
      model = model_step(model, data[i]);
    end
  endtask

  task automatic t_reset();
    load_seed(16'hFFFF, 1'b0);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 sig_so after reset", {15'h0, sig_so}, 16'h0);
    unload("R1 register cleared", 16'h0000);
  endtask

  task automatic t_roundtrip(input logic [15:0] seed);
    load_seed(seed, 1'b1);
    chk("R9 sig_so is bit 0", {15'h0, sig_so}, {15'h0, seed[0]});
    unload("R4 seed roundtrip", seed);
  endtask

  task automatic t_select_ignores_chain();
    load_seed(16'h5A3C, 1'b0);
    unload("R5 chain_di ignored in select", 16'h5A3C);
  endtask

  task automatic t_compact(input logic [15:0] seed, input logic [31:0] data, input int nbits);
    load_seed(seed, 1'b0);
    compact(data, nbits, 1'b0);
    unload("R6 signature", model);
  endtask

  task automatic t_on_ignores_tdi();
    logic [15:0] exp;
    load_seed(16'h1234, 1'b0);
    compact(32'hC0FFEE11, 32, 1'b1);
    exp = model;
    unload("R7 tdi ignored in on mode", exp);
  endtask

  task automatic t_off_hold(input logic [1:0] m, input string req);
    load_seed(16'hBEEF, 1'b0);
    tap_state = ST_SHIFT; mode = m;
    for (int i = 0; i < 8; i++) begin
      tdi = i[0]; chain_di = ~i[0];
      tick();
    end
    unload(req, 16'hBEEF);
  endtask

  task automatic t_idle_hold();
    load_seed(16'h8421, 1'b0);
    tap_state = ST_PAUSE;
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      for (int i = 0; i < 4; i++) begin
        tdi = i[0]; chain_di = i[1];
        tick();
      end
    end
    tap_state = 4'h0; mode = 2'b10; chain_di = 1'b1; tick();
    unload("R2 hold outside Shift-DR", 16'h8421);
  endtask

  task automatic t_compact_then_freeze();
    load_seed(16'h0000, 1'b0);
    compact(32'h1, 1, 1'b0);
    chk("R6 single one from zero", model, 16'h1021);
    mode = 2'b00; tap_state = ST_SHIFT; chain_di = 1'b1; tick();
    unload("R9 signature readout after off", 16'h1021);
  endtask

  initial begin
    tick(); tick();
    rst = 1'b0;
    chk("R1 reset state", {15'h0, sig_so}, 16'h0);
    unload("R1 reset contents", 16'h0000);
    t_reset();
    t_roundtrip(16'hA5C3);
    t_roundtrip(16'h0001);
    t_roundtrip(16'h8000);
    t_select_ignores_chain();
    t_compact(16'h0000, 32'hDEADBEEF, 32);
    t_compact(16'hFFFF, 32'h00000000, 20);
    t_compact(16'h1D0F, 32'h0000A55A, 16);
    t_on_ignores_tdi();
    t_off_hold(2'b00, "R8 off mode 00 holds");
    t_off_hold(2'b11, "R3 code 11 acts as off");
    t_idle_hold();
    t_compact_then_freeze();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule